// File: doc/BRIEF.md
# Laser Eye-Safety Fault Controller

This block is the digital supervisor that decides, cycle by cycle, whether a laser driver may be switched on. It watches two fault comparator outputs (excess bias current and excess average optical power), a bias-out-of-range monitor, a manual shut-off input, an active-low clear strobe and a supply-good indication. All of these arrive asynchronously and each passes through a two-stage synchroniser before any logic uses it.

A fault must persist for a qualification window before it latches. While latched, the laser stays off. A clear strobe that is held low long enough removes the latch, and so does a loss of supply. Shorter strobes are ignored. A separate power-on path keeps the laser dark until the supply has been good for a programmable delay. The bias-monitor alarm is only a status indication: it follows its input and never gates the laser.

Top module: `laser_safety_ctrl`

## Requirements
- R1: When either fault input (bias_hi_i or pwr_hi_i) is seen high after synchronisation for QUAL_CYC consecutive cycles, fault_o goes high on the following cycle and laser_en_o goes low one cycle after that.
- R2: The qualification count restarts whenever both fault inputs are low. Bursts of QUAL_CYC-1 cycles separated by a low gap never set fault_o.
- R3: Once fault_o is high it stays high until a valid clear strobe or a loss of supply, and laser_en_o stays low while it is high.
- R4: A clear strobe (strobe_n_i low) held for at least RST_MIN_CYC synchronised cycles clears fault_o when the strobe is released.
- R5: A clear strobe held low for fewer than RST_MIN_CYC cycles has no effect on a latched fault.
- R6: While strobe_n_i is low, laser_en_o is low.
- R7: laser_off_i high forces laser_en_o low regardless of the fault state, and it does not change fault_o.
- R8: supply_ok_i low forces laser_en_o low and clears fault_o. laser_en_o can return only after the supply has been good for POR_CYC synchronised cycles.
- R9: bias_alarm_o follows bias_oor_i two cycles later. It is not latched and affects neither laser_en_o nor fault_o.
- R10: When a valid clear and a completing fault qualification fall in the same cycle, the clear wins and the qualification count restarts from zero.
- R11: After sys_rst_n, laser_en_o, fault_o and bias_alarm_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| sys_rst_n | input | 1 | Asynchronous active-low logic reset |
| bias_hi_i | input | 1 | Bias current above limit (async) |
| pwr_hi_i | input | 1 | Average power above limit (async) |
| bias_oor_i | input | 1 | Bias outside normal range (async) |
| laser_off_i | input | 1 | Manual laser shut-off, active high (async) |
| strobe_n_i | input | 1 | Fault clear strobe, active low (async) |
| supply_ok_i | input | 1 | Supply above threshold (async) |
| laser_en_o | output | 1 | Laser driver enable |
| fault_o | output | 1 | Latched eye-safety fault |
| bias_alarm_o | output | 1 | Unlatched bias-range alarm |

## Verification
The clear produced by releasing a long strobe can land in the same cycle in which a fault finishes its qualification window. The bench raises a fault QUAL_CYC-2 cycles before it releases a strobe that is already long enough, which makes both events complete on one edge. The per-cycle model expects the clear to take priority: fault_o must stay low at that point and rise only after a full new qualification window. A supply drop during the power-on count is also exercised, to confirm that the delay restarts from zero.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int SYNC_W   = 6;
    localparam int IX_BIAS  = 0;
    localparam int IX_PWR   = 1;
    localparam int IX_OOR   = 2;
    localparam int IX_OFF   = 3;
    localparam int IX_STRB  = 4;
    localparam int IX_SUP   = 5;

    typedef struct packed {
        logic en;
    } top_st_t;
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         sys_rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            st_d.s1[b] = async_i[b];
            st_d.s2[b] = st_q.s1[b];
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        1'b1 |=> sync_o == $past(st_q.s1));
endmodule

// File: rtl/lsc_strobe.sv
module lsc_strobe #(
    parameter int MIN_CYC = 20
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic strb_n_s,
    output logic clr_o
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          clr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.clr = strb_n_s && (st_q.cnt == LIM);
        if (strb_n_s)          st_d.cnt = '0;
        else if (st_q.cnt != LIM) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign clr_o = st_q.clr;

    assert_no_clr_while_low_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !strb_n_s |=> !clr_o);
    assert_clr_single_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        clr_o |=> !clr_o);
endmodule

// File: rtl/lsc_qual.sv
module lsc_qual #(
    parameter int QUAL_CYC = 8
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic fault_s,
    input  logic supply_s,
    input  logic clr_i,
    output logic latch_o
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LIM  = CW'(QUAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          latch;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_s || clr_i) begin
            st_d = '0;
        end else begin
            if (fault_s && st_q.cnt == LAST) st_d.latch = 1'b1;
            if (!fault_s)            st_d.cnt = '0;
            else if (st_q.cnt != LIM) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign latch_o = st_q.latch;

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        latch_o && supply_s && !clr_i |=> latch_o);
    assert_no_latch_idle_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !latch_o && !fault_s |=> !latch_o);
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        clr_i |=> !latch_o);
endmodule

// File: rtl/lsc_por.sv
module lsc_por #(
    parameter int POR_CYC = 16
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic supply_s,
    output logic ready_o
);
    localparam int CW = $clog2(POR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_s) begin
            st_d = '0;
        end else if (!st_q.ready) begin
            st_d.ready = (st_q.cnt == LAST);
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    assert_supply_drop_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !supply_s |=> !ready_o);
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
    import lsc_pkg::*;
#(
    parameter int QUAL_CYC    = 1000,
    parameter int POR_CYC     = 40000,
    parameter int RST_MIN_CYC = 1200000
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic bias_hi_i,
    input  logic pwr_hi_i,
    input  logic bias_oor_i,
    input  logic laser_off_i,
    input  logic strobe_n_i,
    input  logic supply_ok_i,
    output logic laser_en_o,
    output logic fault_o,
    output logic bias_alarm_o
);
    logic [SYNC_W-1:0] raw, syn;
    logic clr, latch, ready;
    top_st_t st_d, st_q;

    always_comb begin
        raw          = '0;
        raw[IX_BIAS] = bias_hi_i;
        raw[IX_PWR]  = pwr_hi_i;
        raw[IX_OOR]  = bias_oor_i;
        raw[IX_OFF]  = laser_off_i;
        raw[IX_STRB] = strobe_n_i;
        raw[IX_SUP]  = supply_ok_i;
    end

    lsc_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .sys_rst_n(sys_rst_n), .async_i(raw), .sync_o(syn));

    lsc_strobe #(.MIN_CYC(RST_MIN_CYC)) u_strobe (
        .clk(clk), .sys_rst_n(sys_rst_n), .strb_n_s(syn[IX_STRB]), .clr_o(clr));

    lsc_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk(clk), .sys_rst_n(sys_rst_n),
        .fault_s(syn[IX_BIAS] | syn[IX_PWR]), .supply_s(syn[IX_SUP]),
        .clr_i(clr), .latch_o(latch));

    lsc_por #(.POR_CYC(POR_CYC)) u_por (
        .clk(clk), .sys_rst_n(sys_rst_n), .supply_s(syn[IX_SUP]), .ready_o(ready));

    always_comb begin
        st_d.en = ready && !latch && !syn[IX_OFF] && syn[IX_STRB];
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign laser_en_o   = st_q.en;
    assign fault_o      = latch;
    assign bias_alarm_o = syn[IX_OOR];

    assert_fault_blocks_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        fault_o |=> !laser_en_o);
    assert_strobe_off_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !syn[IX_STRB] |=> !laser_en_o);
    assert_manual_off_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        syn[IX_OFF] |=> !laser_en_o);
    assert_por_gate_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !ready |=> !laser_en_o);
endmodule

// File: tb/sim_laser_safety_ctrl.sv
module sim_laser_safety_ctrl;
    localparam int Q = 8;
    localparam int P = 16;
    localparam int RM = 20;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic bias_hi = 0, pwr_hi = 0, oor = 0, off = 0, strb_n = 1, sup = 0;
    logic en, flt, alarm;

    int n_chk = 0, n_fail = 0, cyc = 0;
    string cur = "R11";

    always #2.5 clk = ~clk;

    laser_safety_ctrl #(.QUAL_CYC(Q), .POR_CYC(P), .RST_MIN_CYC(RM)) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .bias_hi_i(bias_hi), .pwr_hi_i(pwr_hi),
        .bias_oor_i(oor), .laser_off_i(off), .strobe_n_i(strb_n), .supply_ok_i(sup),
        .laser_en_o(en), .fault_o(flt), .bias_alarm_o(alarm));

    // behavioural reference: two sample delays then counters
    logic [5:0] m1, m2;
    int rc, qc, pc;
    logic clr_m, lat_m, rdy_m, en_m;

    always @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            m1 = '0; m2 = '0; rc = 0; qc = 0; pc = 0;
            clr_m = 0; lat_m = 0; rdy_m = 0; en_m = 0;
        end else begin
            logic f, s, rs, o, n_clr, n_lat, n_rdy, n_en;
            int n_rc, n_qc, n_pc;
            f = m2[0] | m2[1]; o = m2[3]; rs = m2[4]; s = m2[5];
            n_clr = rs && (rc >= RM);
            n_rc  = rs ? 0 : ((rc < RM) ? rc + 1 : rc);
            n_lat = lat_m; n_qc = qc;
            if (!s || clr_m) begin
                n_lat = 0; n_qc = 0;
            end else begin
                if (f && qc == Q - 1) n_lat = 1;
                n_qc = f ? ((qc < Q) ? qc + 1 : qc) : 0;
            end
            n_rdy = rdy_m; n_pc = pc;
            if (!s) begin
                n_rdy = 0; n_pc = 0;
            end else if (!rdy_m) begin
                if (pc == P - 1) n_rdy = 1;
                n_pc = pc + 1;
            end
            n_en = rdy_m && !lat_m && !o && rs;
            clr_m = n_clr; rc = n_rc; lat_m = n_lat; qc = n_qc;
            rdy_m = n_rdy; pc = n_pc; en_m = n_en;
            m2 = m1;
            m1 = {sup, strb_n, off, oor, pwr_hi, bias_hi};
        end
    end

    task automatic chk(string req, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (sys_rst_n) begin
            chk(cur, en, en_m, "laser_en_o");
            chk(cur, flt, lat_m, "fault_o");
            chk(cur, alarm, m2[2], "bias_alarm_o");
        end
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        cur = "R11";
        chk("R11", en, 1'b0, "reset en"); chk("R11", flt, 1'b0, "reset fault");
        chk("R11", alarm, 1'b0, "reset alarm");
        sys_rst_n = 1'b1;
        sup = 1;
        cur = "R8"; wait_cyc(P - 2); chk("R8", en, 1'b0, "en before por");
        wait_cyc(8); chk("R8", en, 1'b1, "en after por");

        cur = "R9"; oor = 1; wait_cyc(5);
        chk("R9", alarm, 1'b1, "alarm on"); chk("R9", en, 1'b1, "en unaffected");
        oor = 0; wait_cyc(4); chk("R9", alarm, 1'b0, "alarm off");

        cur = "R2"; bias_hi = 1; wait_cyc(Q - 1); bias_hi = 0; wait_cyc(2);
        pwr_hi = 1; wait_cyc(Q - 1); pwr_hi = 0; wait_cyc(5);
        chk("R2", flt, 1'b0, "split bursts");

        cur = "R7"; off = 1; wait_cyc(4); chk("R7", en, 1'b0, "manual off");
        off = 0; wait_cyc(4); chk("R7", en, 1'b1, "manual on");

        cur = "R1"; bias_hi = 1; wait_cyc(Q); bias_hi = 0; wait_cyc(5);
        chk("R1", flt, 1'b1, "fault latched"); chk("R3", en, 1'b0, "en off on fault");
        cur = "R7"; off = 1; wait_cyc(3); off = 0; wait_cyc(3);
        chk("R7", flt, 1'b1, "off leaves fault");

        cur = "R5"; strb_n = 0; wait_cyc(RM - 1); strb_n = 1; wait_cyc(6);
        chk("R5", flt, 1'b1, "short strobe ignored");

        cur = "R4"; strb_n = 0; wait_cyc(RM); strb_n = 1; wait_cyc(6);
        chk("R4", flt, 1'b0, "strobe clears"); chk("R4", en, 1'b1, "en back");

        cur = "R6"; strb_n = 0; wait_cyc(4); chk("R6", en, 1'b0, "en low in strobe");
        strb_n = 1; wait_cyc(4); chk("R6", en, 1'b1, "en after strobe");

        cur = "R1"; pwr_hi = 1; wait_cyc(Q + 3); pwr_hi = 0; wait_cyc(2);
        chk("R1", flt, 1'b1, "power fault latched");

        cur = "R8"; sup = 0; wait_cyc(4);
        chk("R8", flt, 1'b0, "supply loss clears"); chk("R8", en, 1'b0, "supply loss off");
        sup = 1; wait_cyc(6); sup = 0; wait_cyc(3); sup = 1;
        wait_cyc(P - 2); chk("R8", en, 1'b0, "por restarted");
        wait_cyc(8); chk("R8", en, 1'b1, "por done");

        cur = "R10"; strb_n = 0; wait_cyc(RM + 5);
        bias_hi = 1; wait_cyc(Q - 2); strb_n = 1;
        wait_cyc(4); chk("R10", flt, 1'b0, "clear wins tie");
        wait_cyc(Q + 2); chk("R10", flt, 1'b1, "requalified");
        bias_hi = 0; wait_cyc(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule